// File: doc/BRIEF.md
# Integer Shift Unit with Selectable Count Saturation or Wrap

This block computes 32-bit integer shifts in a fully defined way for every shift count an 8-bit count field can hold, including counts at or beyond the data width. It offers plain left shifts and right shifts. Right shifts can fill either with zeros or with copies of the sign bit. It also offers funnel shifts in both directions, which take the two source operands as one 64-bit value (operand A high, operand B low) and return one 32-bit slice of it.

A run-time mode input selects how oversized counts are treated. In saturate mode, any count above the width acts as a shift by exactly the width. In wrap mode, the count is reduced modulo the width, keeping its low five bits. The shift datapath is combinational. By default a single output register stage follows it, with a valid flag that tracks the input valid one cycle later. A parameter removes that stage.

Top module: `shu_top`

## Requirements
- R1: For op code 001 with `signed_sel`=1, the vacated high bits of the result are copies of bit 31 of `src_a`.
- R2: For op code 000, and for op code 001 with `signed_sel`=0, vacated bits are filled with zero. `signed_sel` has no effect on op codes 000, 010 and 011.
- R3: With `wrap_mode`=0, a count above 32 behaves as a count of exactly 32. Op code 000 by 32 gives 0x00000000. Op code 001 by 32 gives 0x00000000 when unsigned and 32 copies of `src_a[31]` when signed.
- R4: With `wrap_mode`=1, the effective count is `shamt` modulo 32 (its low five bits), so a count of 32+k acts as k.
- R5: Op code 010 (funnel left) returns bits 63..32 of {`src_a`,`src_b`} shifted left by the effective count.
- R6: Op code 011 (funnel right) returns bits 31..0 of {`src_a`,`src_b`} shifted right by the effective count, filling with zero.
- R7: A funnel shift with an effective count of 0 returns `src_a` unchanged for 010 and `src_b` unchanged for 011.
- R8: With `wrap_mode`=0 and a count of 32 or more, funnel left returns `src_b` and funnel right returns `src_a`. The result is therefore zero when that incoming operand is zero.
- R9: Op codes 100 to 111 produce a result of 0x00000000.
- R10: With the output stage present (`REG_OUT`=1), `out_valid` equals `in_valid` one cycle later, and `result` then holds the value computed from the inputs of that earlier cycle. During reset, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| op_sel | input | 3 | 000 left, 001 right, 010 funnel left, 011 funnel right, others give zero |
| signed_sel | input | 1 | 1 makes right shifts fill with the sign bit |
| wrap_mode | input | 1 | 0 saturates the count at 32, 1 takes it modulo 32 |
| src_a | input | 32 | Shifted operand, and the high half for funnel shifts |
| src_b | input | 32 | Low half for funnel shifts |
| shamt | input | 8 | Requested shift count, 0 to 255 |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Shift result |

## Verification
The bench builds the block with its defaults: 32-bit data, an 8-bit count and the registered output stage. With these values every count from 0 to 255 can be applied, so both modes are tested well past the width. This covers saturation at exactly 32, counts above it, and wrap-around at 32, 64 and above. The registered stage makes the one-cycle latency of the valid flag observable, along with its reset state. Directed vectors cover the sign-fill, zero-count and zero-incoming-operand corners. A long run of random operands, counts, modes and op codes, including the undefined codes, is then checked against a bit-by-bit model.

// File: rtl/shu_pkg.sv
package shu_pkg;

    typedef enum logic [2:0] {
        OP_SHL  = 3'b000,
        OP_SHR  = 3'b001,
        OP_FUNL = 3'b010,
        OP_FUNR = 3'b011
    } shu_op_e;

endpackage

// File: rtl/shu_count_norm.sv
module shu_count_norm #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] shamt,
    input  logic             wrap_mode,
    output logic [SH_W:0]    eff_cnt
);
    logic over_width;

    // Counts above the width saturate to the width itself.
    assign over_width = (shamt >= CNT_W'(DATA_W));

    always_comb begin
        if (wrap_mode) begin
            // Modulo the width: keep only the low bits.
            eff_cnt = {1'b0, shamt[SH_W-1:0]};
        end else if (over_width) begin
            eff_cnt = (SH_W+1)'(DATA_W);
        end else begin
            eff_cnt = shamt[SH_W:0];
        end
    end
endmodule

// File: rtl/shu_core.sv
module shu_core
    import shu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic [2:0]        op_sel,
    input  logic              signed_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [SH_W:0]     eff_cnt,
    output logic [DATA_W-1:0] shift_res
);
    logic [PAIR_W-1:0]        pair;
    logic [PAIR_W-1:0]        pair_left;
    logic [PAIR_W-1:0]        pair_right;
    logic [PAIR_W-1:0]        single_left;
    logic [DATA_W-1:0]        fill_word;
    logic signed [PAIR_W-1:0] single_ext;
    logic signed [PAIR_W-1:0] single_right;
    shu_op_e                  op;

    assign op        = shu_op_e'(op_sel);
    assign pair      = {src_a, src_b};
    assign fill_word = {DATA_W{signed_sel & src_a[DATA_W-1]}};
    assign single_ext = $signed({fill_word, src_a});

    // Shifting inside a double-width field makes a count equal to the
    // width well defined without a special case.
    always_comb begin
        pair_left    = pair << eff_cnt;
        pair_right   = pair >> eff_cnt;
        single_left  = {{DATA_W{1'b0}}, src_a} << eff_cnt;
        single_right = single_ext >>> eff_cnt;
    end

    always_comb begin
        unique case (op)
            OP_SHL:  shift_res = single_left[DATA_W-1:0];
            OP_SHR:  shift_res = single_right[DATA_W-1:0];
            OP_FUNL: shift_res = pair_left[PAIR_W-1:DATA_W];
            OP_FUNR: shift_res = pair_right[DATA_W-1:0];
            default: shift_res = '0;
        endcase
    end
endmodule

// File: rtl/shu_out_stage.sv
module shu_out_stage #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_data  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_data <= in_data;
                    end
                end
            end
        end else begin : g_pass
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end
    endgenerate
endmodule

// File: rtl/shu_top.sv
module shu_top #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              signed_sel,
    input  logic              wrap_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [CNT_W-1:0]  shamt,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    logic [SH_W:0]     eff_cnt;
    logic [DATA_W-1:0] shift_res;

    shu_count_norm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_norm (
        .shamt     (shamt),
        .wrap_mode (wrap_mode),
        .eff_cnt   (eff_cnt)
    );

    shu_core #(.DATA_W(DATA_W)) u_core (
        .op_sel     (op_sel),
        .signed_sel (signed_sel),
        .src_a      (src_a),
        .src_b      (src_b),
        .eff_cnt    (eff_cnt),
        .shift_res  (shift_res)
    );

    shu_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (shift_res),
        .out_valid (out_valid),
        .out_data  (result)
    );
endmodule

// File: rtl/shu_checker.sv
module shu_checker #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic              signed_sel,
    input logic              wrap_mode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [CNT_W-1:0]  shamt,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    localparam int SH_W = $clog2(DATA_W);

    logic big_cnt;
    logic zero_eff;
    assign big_cnt  = !wrap_mode && (shamt >= CNT_W'(DATA_W));
    assign zero_eff = (shamt == '0) || (wrap_mode && shamt[SH_W-1:0] == '0);

    generate
        if (REG_OUT) begin : g_chk
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == $past(in_valid)) else $error("valid latency"); // R10

            AST_SHL_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 3'b000 && big_cnt) |=> (result == '0)); // R3

            AST_SHR_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 3'b001 && signed_sel && big_cnt)
                |=> (result == {DATA_W{$past(src_a[DATA_W-1])}})); // R1

            AST_FUNNEL_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 3'b010 && zero_eff) |=> (result == $past(src_a))); // R7

            AST_FUNNEL_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 3'b011 && big_cnt && src_a == '0) |=> (result == '0)); // R8

            AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel[2]) |=> (result == '0)); // R9
        end
    endgenerate
endmodule

bind shu_top shu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .signed_sel (signed_sel),
    .wrap_mode  (wrap_mode),
    .src_a      (src_a),
    .src_b      (src_b),
    .shamt      (shamt),
    .out_valid  (out_valid),
    .result     (result)
);

// File: tb/sim_shu_top.sv
module sim_shu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        signed_sel = 1'b0;
    logic        wrap_mode = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [7:0]  shamt = '0;
    logic        out_valid;
    logic [31:0] result;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic        exp_valid = 1'b0;
    logic [31:0] exp_res = '0;
    string       exp_tag = "R10";

    always #5 clk = ~clk;

    shu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .signed_sel(signed_sel), .wrap_mode(wrap_mode), .src_a(src_a),
        .src_b(src_b), .shamt(shamt), .out_valid(out_valid), .result(result)
    );

    // Bit-by-bit reference.
    function automatic logic [31:0] model(input logic [2:0] op, input logic sg,
                                          input logic wr, input logic [31:0] a,
                                          input logic [31:0] b, input logic [7:0] c);
        int e;
        logic [63:0] cat;
        logic [31:0] r;
        logic fill;
        if (wr) e = int'(c) % 32;
        else    e = (int'(c) > 32) ? 32 : int'(c);
        cat  = {a, b};
        fill = sg & a[31];
        r    = '0;
        for (int i = 0; i < 32; i++) begin
            case (op)
                3'b000: r[i] = (i - e >= 0) ? a[i - e] : 1'b0;
                3'b001: r[i] = (i + e < 32) ? a[i + e] : fill;
                3'b010: r[i] = (i + 32 - e >= 0) ? cat[i + 32 - e] : 1'b0;
                3'b011: r[i] = (i + e < 64) ? cat[i + e] : 1'b0;
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic sg, input logic wr);
        if (op[2])        return "R9";
        if (wr)           return "R4";
        if (op == 3'b000) return "R2";
        if (op == 3'b001) return sg ? "R1" : "R2";
        if (op == 3'b010) return "R5";
        return "R6";
    endfunction

    task automatic compare();
        vectors++;
        if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL R10 out_valid actual %0b expected %0b", out_valid, exp_valid);
        end else if (exp_valid && result !== exp_res) begin
            errors++;
            $display("FAIL %s result actual %08h expected %08h", exp_tag, result, exp_res);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic sg,
                        input logic wr, input logic [31:0] a, input logic [31:0] b,
                        input logic [7:0] c, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; op_sel = op; signed_sel = sg; wrap_mode = wr;
        src_a = a; src_b = b; shamt = c;
        exp_valid = v;
        exp_res   = model(op, sg, wr, a, b, c);
        exp_tag   = tag;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || result !== 32'h0) begin
            errors++;
            $display("FAIL R10 reset actual %0b/%08h expected 0/00000000", out_valid, result);
        end
        rst_n = 1'b1;

        step(1, 3'b001, 1, 0, 32'h8000_1234, 0, 8'd4,   "R1");
        step(1, 3'b001, 1, 0, 32'h8000_0000, 0, 8'd32,  "R3");
        step(1, 3'b001, 1, 0, 32'hF000_0000, 0, 8'd200, "R3");
        step(1, 3'b001, 0, 0, 32'hF000_0000, 0, 8'd32,  "R3");
        step(1, 3'b001, 0, 0, 32'h8765_4321, 0, 8'd8,   "R2");
        step(1, 3'b000, 1, 0, 32'hFFFF_FFFF, 0, 8'd4,   "R2");
        step(1, 3'b000, 0, 0, 32'hFFFF_FFFF, 0, 8'd32,  "R3");
        step(1, 3'b000, 0, 0, 32'hFFFF_FFFF, 0, 8'd255, "R3");
        step(1, 3'b000, 0, 1, 32'h0000_0001, 0, 8'd33,  "R4");
        step(1, 3'b001, 1, 1, 32'h8000_0000, 0, 8'd64,  "R4");
        step(1, 3'b010, 0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 8'd8,  "R5");
        step(1, 3'b010, 1, 1, 32'h1234_5678, 32'h9ABC_DEF0, 8'd40, "R5");
        step(1, 3'b011, 0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 8'd12, "R6");
        step(1, 3'b011, 1, 0, 32'hF234_5678, 32'h9ABC_DEF0, 8'd16, "R6");
        step(1, 3'b010, 0, 0, 32'hCAFE_BABE, 32'h1, 8'd0,  "R7");
        step(1, 3'b011, 0, 1, 32'h1, 32'hCAFE_BABE, 8'd96, "R7");
        step(1, 3'b010, 0, 0, 32'hFFFF_FFFF, 32'h0, 8'd32,  "R8");
        step(1, 3'b011, 0, 0, 32'h0, 32'hFFFF_FFFF, 8'd150, "R8");
        step(1, 3'b010, 0, 0, 32'h0, 32'h5555_AAAA, 8'd77, "R8");
        step(1, 3'b100, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd1, "R9");
        step(1, 3'b111, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd0, "R9");
        step(0, 3'b000, 0, 0, 32'h1, 0, 8'd0, "R10");
        step(1, 3'b000, 0, 0, 32'h1, 0, 8'd1, "R10");
        step(0, 3'b001, 0, 0, 32'h2, 0, 8'd1, "R10");

        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            logic sg, wr, v;
            op = 3'($urandom);
            sg = 1'($urandom);
            wr = 1'($urandom);
            v  = ($urandom % 8) != 0;
            step(v, op, sg, wr, $urandom, $urandom, 8'($urandom), tag_of(op, sg, wr));
        end
        step(0, 3'b000, 0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        compare();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule